// File: doc/BRIEF.md
# Delta-Sigma Fractional-N Divider Controller

This block sits in the feedback path of a fractional-N frequency synthesizer. It contains a counter-based programmable divider that runs on the oscillator-side clock. It also contains a second-order cascaded noise-shaping modulator, which picks the modulus for every division. The division setting has three parts: an integer part, a 16-bit fractional word and a half-step flag. The modulus changes from one division to the next, and over many divisions its mean equals the setting. The quantisation error is pushed towards high offset frequencies, where the loop filter removes it. The feedback output is one clock wide and is sent to the phase detector.

The modulator reads the setting and advances only at the divider's terminal count. A setting that changes in the middle of a division therefore takes effect at the next division. An optional pseudo-random dither on the fractional LSB breaks up the idle tones that a plain rational fraction would produce.

Top module: `fracn_mod_ctrl`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` is 0 and `cur_mod` is 0.
- R2: `fb_pulse` is high for exactly one clock per division. The number of clocks from one pulse to the next equals the `cur_mod` value shown during that division.
- R3: `cur_mod` changes only in the clock after a terminal count. A change to the setting in the middle of a division does not alter the length of that division.
- R4: With `frac_word` = 0, `half_en` = 0 and `dither_en` = 0, every division is exactly `int_div` clocks long.
- R5: With dither off, the total length of P divisions after reset is within 2 clocks of P·(`int_div` + `frac_word`/65536).
- R6: Each modulus lies in the range `int_div`−1 to `int_div`+2 when the half flag adds no carry, and one higher when it does. `int_div` must be at least 3.
- R7: `half_en` = 1 adds 0.5 to the setting, which is the value 32768 added to the fractional word with its carry passed into the integer part. For example, `int_div` = 56 gives a mean of 56.5 and `int_div` = 63 gives 63.5.
- R8: `dither_en` = 1 adds one pseudo-random bit to the fractional LSB. With `frac_word` = 0, the moduli then vary between divisions while staying in the R6 range, and the mean stays within 2 clocks of the integer setting over 2000 divisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-side clock that the divider counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_div | input | INT_W | Integer part of the division setting (at least 3) |
| frac_word | input | FRAC_W | Fractional part of the setting, in units of 1/2^FRAC_W |
| half_en | input | 1 | Adds one half to the setting |
| dither_en | input | 1 | Enables pseudo-random LSB dither |
| fb_pulse | output | 1 | One-clock pulse per completed division |
| cur_mod | output | INT_W+2 | Modulus of the division in progress |

## Verification
The bench builds the block with its defaults: an 8-bit integer part and a 16-bit fractional word. With these widths, the half-step range from 56.5 to 63.5 and the full modulus swing of −1 to +3 both fit in `cur_mod` without wrapping. Integer parts between 5 and 63 keep runs of a thousand or more divisions short. At that length the telescoping error bound of the mean can be checked exactly, and a dithered zero fraction builds enough second-stage accumulation to make the modulus toggle.

// File: rtl/fracn_mod_ctrl.sv
module fracn_mod_ctrl #(
  parameter int INT_W = 8,
  parameter int FRAC_W = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  int_div,
  input  logic [FRAC_W-1:0] frac_word,
  input  logic              half_en,
  input  logic              dither_en,
  output logic              fb_pulse,
  output logic [INT_W+1:0]  cur_mod
);
  localparam int MOD_W = INT_W + 2;
  localparam int EFF_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc1, acc2;
  logic              c2_d;
  logic [MOD_W-1:0]  cnt, mod_q;
  logic              run;
  logic [15:0]       lfsr;

  wire              dith = dither_en & lfsr[0];
  wire [EFF_W-1:0]  half_add = half_en ? {2'b01, {(FRAC_W-1){1'b0}}} : '0;
  wire [EFF_W-1:0]  eff = {1'b0, frac_word} + half_add + EFF_W'(dith);
  wire [FRAC_W:0]   s1 = {1'b0, acc1} + {1'b0, eff[FRAC_W-1:0]};
  wire [FRAC_W:0]   s2 = {1'b0, acc2} + {1'b0, s1[FRAC_W-1:0]};
  wire              c1 = s1[FRAC_W];
  wire              c2 = s2[FRAC_W];
  wire [MOD_W-1:0]  mod_next = MOD_W'(int_div) + MOD_W'(eff[FRAC_W])
                             + MOD_W'(c1) + MOD_W'(c2) - MOD_W'(c2_d);
  wire              tc = (cnt == '0);
  wire              lfsr_fb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  assign fb_pulse = tc & run;
  assign cur_mod  = mod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc1  <= '0;
      acc2  <= '0;
      c2_d  <= 1'b0;
      cnt   <= '0;
      mod_q <= '0;
      run   <= 1'b0;
      lfsr  <= LFSR_SEED;
    end else begin
      run <= 1'b1;
      if (tc) begin
        cnt   <= mod_next - MOD_W'(1);
        mod_q <= mod_next;
        acc1  <= s1[FRAC_W-1:0];
        acc2  <= s2[FRAC_W-1:0];
        c2_d  <= c2;
        if (dither_en) lfsr <= {lfsr[14:0], lfsr_fb};
      end else begin
        cnt <= cnt - MOD_W'(1);
      end
    end
  end
endmodule

// File: rtl/fracn_mod_ctrl_chk.sv
module fracn_mod_ctrl_chk #(
  parameter int INT_W = 8,
  parameter int MOD_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [INT_W-1:0] int_div,
  input logic             fb_pulse,
  input logic [MOD_W-1:0] cur_mod,
  input logic             tc
);
  p_quiet_reset_r1: assert property (@(posedge clk) !rst_n |-> !fb_pulse);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  p_mod_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(cur_mod));

  p_mod_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> ((cur_mod + MOD_W'(1) >= MOD_W'($past(int_div))) &&
            (cur_mod <= MOD_W'($past(int_div)) + MOD_W'(3))));
endmodule

bind fracn_mod_ctrl fracn_mod_ctrl_chk #(.INT_W(INT_W), .MOD_W(MOD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .int_div(int_div),
  .fb_pulse(fb_pulse), .cur_mod(cur_mod), .tc(tc)
);

// File: tb/fracn_mod_ctrl_tb_top.sv
module fracn_mod_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] int_div = 8'd10;
  logic [15:0] frac_word = '0;
  logic       half_en = 1'b0;
  logic       dither_en = 1'b0;
  logic       fb_pulse;
  logic [9:0] cur_mod;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_mod_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .int_div(int_div), .frac_word(frac_word),
    .half_en(half_en), .dither_en(dither_en), .fb_pulse(fb_pulse), .cur_mod(cur_mod)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int n, input int f, input bit h, input bit d);
    @(negedge clk);
    rst_n = 1'b0;
    int_div = 8'(n);
    frac_word = 16'(f);
    half_en = h;
    dither_en = d;
    repeat (3) @(negedge clk);
    chk(fb_pulse == 1'b0, "R1 pulse in reset", longint'(fb_pulse), 0);
    chk(cur_mod == '0, "R1 modulus in reset", longint'(cur_mod), 0);
    rst_n = 1'b1;
  endtask

  task automatic measure(input int p, output longint total, output int mn,
                         output int mx, output int bad);
    total = 0; mn = 1 << 20; mx = 0; bad = 0;
    do @(negedge clk); while (!fb_pulse);
    for (int i = 0; i < p; i++) begin
      int c = 0;
      do begin @(negedge clk); c++; end while (!fb_pulse);
      if (c != int'(cur_mod)) bad++;
      total += c;
      if (c < mn) mn = c;
      if (c > mx) mx = c;
    end
  endtask

  task automatic t_integer();
    longint tot; int mn, mx, bad;
    setup(10, 0, 0, 0);
    measure(256, tot, mn, mx, bad);
    chk(tot == 2560, "R4 total", tot, 2560);
    chk(mn == 10 && mx == 10, "R4 no toggling", mx * 1000 + mn, 10010);
    chk(bad == 0, "R2 interval vs cur_mod", bad, 0);
  endtask

  task automatic t_frac(input int n, input int f, input int p);
    longint tot; int mn, mx, bad; real expv, diff;
    setup(n, f, 0, 0);
    measure(p, tot, mn, mx, bad);
    expv = real'(p) * (real'(n) + real'(f) / 65536.0);
    diff = real'(tot) - expv;
    chk(diff <= 2.0 && diff >= -2.0, "R5 mean", tot, longint'($rtoi(expv)));
    chk(mn >= n - 1 && mx <= n + 2, "R6 range", mx * 1000 + mn, (n + 2) * 1000 + n - 1);
    chk(bad == 0, "R2 interval vs cur_mod", bad, 0);
  endtask

  task automatic t_half(input int n, input int f);
    longint tot; int mn, mx, bad; real expv, diff;
    setup(n, f, 1, 0);
    measure(256, tot, mn, mx, bad);
    expv = 256.0 * (real'(n) + 0.5 + real'(f) / 65536.0);
    diff = real'(tot) - expv;
    chk(diff <= 2.0 && diff >= -2.0, "R7 half-step mean", tot, longint'($rtoi(expv)));
    chk(mn >= n - 1 && mx <= n + 3, "R6 range half", mx * 1000 + mn, (n + 3) * 1000 + n - 1);
  endtask

  task automatic t_dither();
    longint tot; int mn, mx, bad;
    setup(8, 0, 0, 1);
    measure(2000, tot, mn, mx, bad);
    chk(mn != mx, "R8 dither toggles", mx, mn + 1);
    chk(mn >= 7 && mx <= 10, "R8 range", mx * 1000 + mn, 10007);
    chk(tot >= 15998 && tot <= 16002, "R8 mean", tot, 16000);
    chk(bad == 0, "R2 interval vs cur_mod dither", bad, 0);
  endtask

  task automatic t_midcount();
    int c;
    setup(20, 0, 0, 0);
    do @(negedge clk); while (!fb_pulse);
    do @(negedge clk); while (!fb_pulse);
    repeat (5) @(negedge clk);
    int_div = 8'd30;
    c = 5;
    do begin @(negedge clk); c++; end while (!fb_pulse);
    chk(c == 20, "R3 running division kept", c, 20);
    c = 0;
    do begin @(negedge clk); c++; end while (!fb_pulse);
    chk(c == 30, "R3 new setting at boundary", c, 30);
    chk(cur_mod == 10'd30, "R3 cur_mod after boundary", longint'(cur_mod), 30);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_integer();
    t_frac(10, 16'h4000, 1024);
    t_frac(12, 16'hA5C3, 1024);
    t_frac(5, 16'h0001, 1024);
    t_half(56, 0);
    t_half(63, 0);
    t_half(20, 16'hC000);
    t_dither();
    t_midcount();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule